// File: doc/BRIEF.md
# Parallel Port Forward-Data Receiver

This block is the peripheral end of an 8-bit compatibility-mode parallel port. The host puts a byte on the data lines and pulses a low-active strobe. The receiver samples that byte and raises BUSY to hold the host off. It hands the byte to downstream logic over a valid/ready stream. Once the sink has taken the byte, it answers the host with a low-active acknowledge pulse.

All port timing is counted in system clock cycles and derived from a clock-frequency parameter. At the default 125 MHz, the minimum strobe width of 500 ns becomes 63 cycles and the acknowledge width of 2 µs becomes 250 cycles.

The strobe, the data lines and the low-active initialise input each pass through a two-flop synchroniser. Strobe pulses shorter than the minimum width are discarded. When the sink is not ready, the receiver keeps BUSY high and holds back the acknowledge, which paces the host all the way from the sink.

Top module: `lpt_fwd_rx`

## Requirements
- R1: After reset, `busy_o` is 0, `ack_n_o` is 1 and `rx_valid_o` is 0.
- R2: `busy_o` is 1 no later than 3 clock cycles after `stb_n_i` falls at the pin, well inside the 500 ns bound. This holds even for a pulse that is later discarded.
- R3: A strobe whose synchronised low run is shorter than the minimum of 63 cycles (for example 62 or 10 cycles) produces no stream transfer and no acknowledge. `busy_o` returns to 0 once the strobe goes high.
- R4: A strobe held low for at least 63 cycles offers the byte on `rx_data_o` with `rx_valid_o` = 1. For an exactly 63-cycle pulse, `rx_valid_o` is 0 after 64 cycles and 1 after 65 cycles, counted from the pin edge.
- R5: While `rx_valid_o` is 1 and `rx_ready_i` is 0, `rx_valid_o`, `rx_data_o` and `busy_o` stay unchanged for as long as the sink stalls.
- R6: In the cycle after a transfer (`rx_valid_o` and `rx_ready_i` both 1), `rx_valid_o` and `busy_o` are 0 and `ack_n_o` goes to 0. `ack_n_o` then stays 0 for exactly 250 cycles.
- R7: A new strobe that falls while the acknowledge pulse is still running is accepted. `busy_o` rises again within 3 cycles, the running acknowledge pulse keeps going, and the new byte is delivered.
- R8: Holding `init_n_i` low for 3 cycles forces the receiver idle: `busy_o` = 0, `rx_valid_o` = 0, and any running acknowledge pulse ends (`ack_n_o` = 1). Strobes are ignored while `init_n_i` is low.
- R9: The delivered byte is the value on `data_i` when the strobe falls. Changing `data_i` later in the pulse does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stb_n_i | input | 1 | Host data strobe, low-active, asynchronous |
| data_i | input | 8 | Host data byte, asynchronous |
| init_n_i | input | 1 | Host initialise request, low-active, asynchronous |
| busy_o | output | 1 | BUSY to host, high while a byte is pending |
| ack_n_o | output | 1 | Acknowledge to host, low-active pulse |
| rx_valid_o | output | 1 | Stream valid toward the sink |
| rx_data_o | output | 8 | Stream byte toward the sink |
| rx_ready_i | input | 1 | Stream ready from the sink |

## Verification
Each result is due a fixed number of rising edges after its stimulus:
- BUSY: 3 edges after the pin strobe falls (two synchroniser stages plus the output register).
- Stream valid: 65 edges after the strobe falls, for a minimum-width pulse.
- Transfer response (BUSY drop, valid drop, acknowledge start): 1 edge after a transfer.
- Initialise: 3 edges after `init_n_i` falls.

The bench drives every input on the falling clock edge and counts falling edges from that point. It samples at exactly these counts, including the 64/65-edge boundary of a 63-cycle pulse and the 62-cycle reject. It measures the acknowledge width by counting the falling edges on which `ack_n_o` is low.

// File: rtl/lpt_rx_pkg.sv
package lpt_rx_pkg;

  // Receiver sequencing states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for a strobe fall
    ST_QUAL  = 2'd1,  // strobe low, width not yet proven
    ST_OFFER = 2'd2   // byte presented on the stream
  } rx_state_e;

  // Round a duration in ns up to whole clock cycles
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned ns);
    longint unsigned prod;
    prod = clk_hz * ns;
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/lpt_in_sync.sv
// Two-flop synchroniser, one chain per bit, each bit with its own reset value
module lpt_in_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end

    assign q_o[i] = sync_q;
  end

endmodule

// File: rtl/lpt_stb_qual.sv
// Counts consecutive synchronised low samples of the strobe.
// Flags the first low sample (fall) and the MIN_CYC-th one (qualified).
module lpt_stb_qual #(
  parameter int MIN_CYC = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,    // synchronised strobe, 1 = low at pin
  output logic fall_o,   // first low sample after a high one
  output logic qual_o    // low run has just reached MIN_CYC samples
);

  localparam int            CW   = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  // Saturating run counter; cleared by any high sample
  always_comb begin
    run_d = run_q;
    if (!low_i) begin
      run_d = '0;
    end else if (run_q != SAT) begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  assign fall_o = low_i && (run_q == '0);
  assign qual_o = low_i && (run_q == LAST);

endmodule

// File: rtl/lpt_ack_gen.sv
// Low-active acknowledge pulse of ACK_CYC cycles.
// A start while running reloads the count; clear ends the pulse at once.
module lpt_ack_gen #(
  parameter int ACK_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic ack_n_o
);

  localparam int            CW   = $clog2(ACK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(ACK_CYC);

  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;
  logic          ack_n_q;
  logic          ack_n_d;

  always_comb begin
    left_d = left_q;
    if (clear_i) begin
      left_d = '0;
    end else if (start_i) begin
      left_d = LOAD;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end
    ack_n_d = (left_d == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      ack_n_q <= 1'b1;
    end else begin
      left_q  <= left_d;
      ack_n_q <= ack_n_d;
    end
  end

  assign ack_n_o = ack_n_q;

  assert_ack_starts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i) |=> !ack_n_o)
    else $error("ack pulse did not start");

  assert_ack_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ack_n_o)
    else $error("ack pulse not cleared by init");

endmodule

// File: rtl/lpt_rx_fsm.sv
// Byte capture, qualification and stream hand-off sequencing
module lpt_rx_fsm
  import lpt_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,     // synchronised initialise, active high
  input  logic          low_i,      // synchronised strobe, 1 = low
  input  logic          fall_i,
  input  logic          qual_i,
  input  logic [DW-1:0] data_i,     // synchronised data
  input  logic          ready_i,
  output logic          busy_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          ack_start_o
);

  rx_state_e     state_q, state_d;
  logic          busy_q, busy_d;
  logic          valid_q, valid_d;
  logic [DW-1:0] byte_q;
  logic          byte_en;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    byte_en     = 1'b0;
    ack_start_o = 1'b0;
    if (init_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            byte_en = 1'b1;
            state_d = qual_i ? ST_OFFER : ST_QUAL;
          end
        end
        ST_QUAL: begin
          if (!low_i) begin
            state_d = ST_IDLE;       // pulse too short: drop it
          end else if (qual_i) begin
            state_d = ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (ready_i) begin
            ack_start_o = 1'b1;
            state_d     = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    busy_d  = (state_d != ST_IDLE);
    valid_d = (state_d == ST_OFFER);
  end

  // State and registered outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      valid_q <= valid_d;
    end
  end

  // Byte register with explicit load enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_q <= '0;
    else if (byte_en) byte_q <= data_i;
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign data_o  = byte_q;

  assert_busy_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !init_i && state_q == ST_IDLE) |=> busy_o)
    else $error("busy not raised on strobe fall");

  assert_short_pulse_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAL && !low_i && !init_i) |=> (!busy_o && !valid_o))
    else $error("short strobe not discarded");

  assert_stall_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !init_i) |=> (valid_o && busy_o && $stable(data_o)))
    else $error("offer changed while sink stalled");

  assert_valid_under_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o)
    else $error("valid without busy");

  assert_handoff_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !init_i) |=> (!busy_o && !valid_o))
    else $error("busy/valid not released after transfer");

  assert_init_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!busy_o && !valid_o))
    else $error("init did not force idle");

endmodule

// File: rtl/lpt_fwd_rx.sv
// Parallel port forward-data receiver (top)
module lpt_fwd_rx
  import lpt_rx_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 125_000_000,
  parameter int              DATA_W     = 8,
  parameter int              STB_MIN_NS = 500,
  parameter int              ACK_NS     = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_n_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              init_n_i,
  output logic              busy_o,
  output logic              ack_n_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_ready_i
);

  localparam int unsigned STB_RAW = ns_to_cycles(CLK_HZ, longint'(STB_MIN_NS));
  localparam int unsigned ACK_RAW = ns_to_cycles(CLK_HZ, longint'(ACK_NS));
  localparam int          STB_CYC = (STB_RAW < 1) ? 1 : int'(STB_RAW);
  localparam int          ACK_CYC = (ACK_RAW < 1) ? 1 : int'(ACK_RAW);
  localparam int          SW      = DATA_W + 2;
  localparam logic [SW-1:0] SYNC_RST = {2'b11, {DATA_W{1'b0}}};

  // Reset: asserted asynchronously, released synchronously
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Input synchronisation: {init_n, stb_n, data}
  logic [SW-1:0] pins_sync;

  lpt_in_sync #(
    .W       (SW),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .d_i    ({init_n_i, stb_n_i, data_i}),
    .q_o    (pins_sync)
  );

  logic              stb_low;
  logic              init_act;
  logic [DATA_W-1:0] data_sync;

  assign data_sync = pins_sync[DATA_W-1:0];
  assign stb_low   = !pins_sync[DATA_W];
  assign init_act  = !pins_sync[DATA_W+1];

  logic fall;
  logic qual;
  logic ack_start;

  lpt_stb_qual #(
    .MIN_CYC (STB_CYC)
  ) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .low_i  (stb_low),
    .fall_o (fall),
    .qual_o (qual)
  );

  lpt_rx_fsm #(
    .DW (DATA_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .init_i      (init_act),
    .low_i       (stb_low),
    .fall_i      (fall),
    .qual_i      (qual),
    .data_i      (data_sync),
    .ready_i     (rx_ready_i),
    .busy_o      (busy_o),
    .valid_o     (rx_valid_o),
    .data_o      (rx_data_o),
    .ack_start_o (ack_start)
  );

  lpt_ack_gen #(
    .ACK_CYC (ACK_CYC)
  ) u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .start_i (ack_start),
    .clear_i (init_act),
    .ack_n_o (ack_n_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    $rose(rst_sync_q) |-> (!busy_o && ack_n_o && !rx_valid_o))
    else $error("outputs not idle after reset");

endmodule

// File: tb/lpt_fwd_rx_tb_top.sv
module lpt_fwd_rx_tb_top;

  localparam int ACK_EXP = 250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb_n = 1'b1;
  logic [7:0] data = 8'h00;
  logic       init_n = 1'b1;
  logic       ready = 1'b0;
  logic       busy;
  logic       ack_n;
  logic       valid;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  lpt_fwd_rx dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .stb_n_i    (stb_n),
    .data_i     (data),
    .init_n_i   (init_n),
    .busy_o     (busy),
    .ack_n_o    (ack_n),
    .rx_valid_o (valid),
    .rx_data_o  (rdata),
    .rx_ready_i (ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Strobe low for 'width' falling edges; optionally change data at edge chg_at.
  // Records busy/ack at edge 3 and the first stream transfer seen.
  task automatic strobe_pulse(input int width, input int chg_at, input logic [7:0] chg_val,
                              output logic busy3, output logic ack3,
                              output bit got, output logic [7:0] got_data);
    got = 1'b0; got_data = 8'h00; busy3 = 1'b0; ack3 = 1'b1;
    stb_n = 1'b0;
    for (int k = 1; k <= width + 80; k++) begin
      @(negedge clk);
      if (k == 3) begin busy3 = busy; ack3 = ack_n; end
      if (valid && ready && !got) begin got = 1'b1; got_data = rdata; end
      if (k == chg_at) data = chg_val;
      if (k == width) stb_n = 1'b1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(6);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(ack_n == 1'b1, "R1", "ack_n after reset", ack_n, 1);
    chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
  endtask

  // Minimum-width pulse, stalled sink, then hand-off and ack width
  task automatic t_min_pulse_stall_ack();
    int ack_len;
    ready = 1'b0;
    data  = 8'hA5;
    wait_neg(20);
    stb_n = 1'b0;
    for (int k = 1; k <= 65; k++) begin
      @(negedge clk);
      if (k == 3)  chk(busy == 1'b1, "R2", "busy 3 cycles after fall", busy, 1);
      if (k == 10) data = 8'h00;
      if (k == 63) stb_n = 1'b1;
      if (k == 64) chk(valid == 1'b0, "R4", "valid at edge 64", valid, 0);
      if (k == 65) begin
        chk(valid == 1'b1, "R4", "valid at edge 65", valid, 1);
        chk(rdata == 8'hA5, "R4", "offered byte", rdata, 8'hA5);
      end
    end
    wait_neg(200);
    chk(valid == 1'b1, "R5", "valid held during stall", valid, 1);
    chk(busy == 1'b1, "R5", "busy held during stall", busy, 1);
    chk(rdata == 8'hA5, "R5", "data held during stall", rdata, 8'hA5);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk(valid == 1'b0, "R6", "valid after transfer", valid, 0);
    chk(busy == 1'b0, "R6", "busy after transfer", busy, 0);
    chk(ack_n == 1'b0, "R6", "ack starts after transfer", ack_n, 0);
    ack_len = (ack_n == 1'b0) ? 1 : 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ack_n == 1'b0) ack_len++;
      else break;
    end
    chk(ack_len == ACK_EXP, "R6", "ack width in cycles", ack_len, ACK_EXP);
    wait_neg(10);
  endtask

  // Pulses just short and far short of the minimum
  task automatic t_short_pulses();
    logic b3, a3; bit got; logic [7:0] gd;
    ready = 1'b1;
    data  = 8'h3C;
    wait_neg(20);
    strobe_pulse(62, 0, 8'h00, b3, a3, got, gd);
    chk(got == 1'b0, "R3", "no transfer for 62-cycle pulse", got, 0);
    chk(busy == 1'b0, "R3", "busy low after 62-cycle pulse", busy, 0);
    chk(ack_n == 1'b1, "R3", "no ack for 62-cycle pulse", ack_n, 1);
    strobe_pulse(10, 0, 8'h00, b3, a3, got, gd);
    chk(b3 == 1'b1, "R2", "busy raised for short pulse", b3, 1);
    chk(got == 1'b0, "R3", "no transfer for 10-cycle pulse", got, 0);
    chk(busy == 1'b0, "R3", "busy low after 10-cycle pulse", busy, 0);
    ready = 1'b0;
  endtask

  // Data changed mid-pulse, then a back-to-back byte during the ack pulse
  task automatic t_hold_and_overlap();
    logic b3, a3; bit got; logic [7:0] gd;
    ready = 1'b1;
    data  = 8'h5A;
    wait_neg(20);
    strobe_pulse(100, 5, 8'hFF, b3, a3, got, gd);
    chk(got == 1'b1, "R4", "transfer for long pulse", got, 1);
    chk(gd == 8'h5A, "R9", "byte sampled at fall", gd, 8'h5A);
    chk(ack_n == 1'b0, "R7", "ack still running", ack_n, 0);
    data = 8'hC3;
    wait_neg(20);
    strobe_pulse(100, 0, 8'h00, b3, a3, got, gd);
    chk(b3 == 1'b1, "R7", "busy for strobe during ack", b3, 1);
    chk(a3 == 1'b0, "R7", "ack continues during new strobe", a3, 0);
    chk(got == 1'b1 && gd == 8'hC3, "R7", "overlapping byte delivered", gd, 8'hC3);
    ready = 1'b0;
    wait_neg(300);
  endtask

  task automatic t_init();
    logic b3, a3; bit got; logic [7:0] gd;
    ready = 1'b0;
    data  = 8'h81;
    wait_neg(20);
    strobe_pulse(100, 0, 8'h00, b3, a3, got, gd);
    chk(valid == 1'b1, "R8", "byte pending before init", valid, 1);
    init_n = 1'b0;
    wait_neg(4);
    chk(busy == 1'b0, "R8", "busy cleared by init", busy, 0);
    chk(valid == 1'b0, "R8", "valid cleared by init", valid, 0);
    strobe_pulse(100, 0, 8'h00, b3, a3, got, gd);
    chk(busy == 1'b0 && valid == 1'b0, "R8", "strobe ignored under init", valid, 0);
    init_n = 1'b1;
    wait_neg(10);
    ready = 1'b1;
    data  = 8'h42;
    wait_neg(20);
    strobe_pulse(100, 0, 8'h00, b3, a3, got, gd);
    chk(got == 1'b1 && gd == 8'h42, "R8", "recovery after init", gd, 8'h42);
    chk(ack_n == 1'b0, "R8", "ack running before init", ack_n, 0);
    init_n = 1'b0;
    wait_neg(4);
    chk(ack_n == 1'b1, "R8", "ack ended by init", ack_n, 1);
    init_n = 1'b1;
    ready  = 1'b0;
    wait_neg(10);
  endtask

  initial begin
    t_reset();
    t_min_pulse_stall_ack();
    t_short_pulses();
    t_hold_and_overlap();
    t_init();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule